// File: doc/BRIEF.md
# RAID6 P/Q Syndrome Engine

This block computes the two RAID6 parity bytes for a set of equal-length byte streams. P is the plain XOR of the source bytes. Q is the XOR of each source byte after it has been multiplied in GF(2^8) by a coefficient chosen for that source. Software-side logic first issues one command. The command sets the operation, the number of sources, one coefficient per source, separate off switches for P and Q, and the stream length in bytes. The data port then takes one beat per byte position. Each beat carries one byte from every source on a shared 64-bit bus.

In generate mode each accepted beat yields a P byte and a Q byte one clock later. In validate mode the block also takes the stored P and Q bytes with each beat and compares them with the recomputed values. It raises a sticky failure bit for each syndrome that ever differs. A done pulse closes every command, and the failure bits are final in that cycle. A continuation of an earlier syndrome needs no special mode. The caller feeds the old P with coefficient 0, the old Q with coefficient 1 and the old Q again with coefficient 0 as extra sources. A single-source multiply is one source given twice, with coefficients c and 0 and P switched off.

Top module: `raid_pq_engine`

## Requirements
- R1: The command field `cmd_code` is 4 bits and holds the source count minus two. Codes 0 to 6 are accepted and select 2 to 8 sources. Source i occupies byte lane i, bits 8i+7 down to 8i, of `in_src`, and its coefficient occupies the same lane of `cmd_coef`.
- R2: A command whose code is 7 or above, or whose length is 0, is rejected. One cycle after the handshake, `done` and `err` are both high for exactly one cycle. `in_ready` stays low and no data is taken.
- R3: `p_data` is the XOR of the bytes in the active lanes. Lanes at or above the source count have no effect on either output.
- R4: `q_data` is the XOR over the active lanes of coefficient times byte in GF(2^8), reduced by the polynomial 0x11D.
- R5: A lane with coefficient 0 changes only P. The extra lanes (old P, coefficient 0), (old Q, coefficient 1) and (old Q, coefficient 0) therefore give the P and Q of the combined source set.
- R6: When P is switched off and two lanes carry the same byte x with coefficients c and 0, `q_data` equals c times x.
- R7: With `cmd_p_off` set, `p_valid` stays low and `p_fail` is never set for that command. `cmd_q_off` has the same effect on `q_valid` and `q_fail`.
- R8: Each accepted data beat raises `p_valid` and `q_valid` (when enabled) with the beat's result in exactly the next cycle. No output valid is raised in a cycle that does not follow an accepted beat.
- R9: `cmd_op` 1 selects validate and 0 selects generate. In validate mode a beat whose enabled P (or Q) differs from `in_p_ref` (or `in_q_ref`) sets `p_fail` (or `q_fail`). The flag stays set through later matching beats and is cleared only when the next command is accepted. Generate mode never sets a flag.
- R10: While a command runs, exactly `cmd_len` beats are accepted and `cmd_ready` is low. `done` pulses for one cycle in the same cycle as the last beat's outputs, and `in_ready` is then low.
- R11: After reset, `cmd_ready` is high and `in_ready`, both output valids, `done`, `err` and both failure flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken on this cycle's edge |
| cmd_op | input | 1 | 0 generate, 1 validate |
| cmd_code | input | 4 | Source count minus two |
| cmd_coef | input | 64 | Per-lane GF(2^8) coefficients |
| cmd_p_off | input | 1 | Switch P off |
| cmd_q_off | input | 1 | Switch Q off |
| cmd_len | input | 16 | Number of beats |
| in_valid | input | 1 | Data beat offered |
| in_ready | output | 1 | Data beat accepted |
| in_src | input | 64 | One byte per source lane |
| in_p_ref | input | 8 | Stored P byte (validate) |
| in_q_ref | input | 8 | Stored Q byte (validate) |
| p_valid | output | 1 | P byte valid |
| p_data | output | 8 | P byte |
| q_valid | output | 1 | Q byte valid |
| q_data | output | 8 | Q byte |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Command rejected, with done |
| p_fail | output | 1 | Sticky P mismatch |
| q_fail | output | 1 | Sticky Q mismatch |

## Verification
The assertions assume that the command fields are stable in the cycle a handshake completes. They also assume that data beats arrive only while a command runs, because `in_ready` is what gates every counter step, flag update and output valid. The stimulus drives commands and beats at the falling edge and holds them until the next rising edge. Beats are only offered after a command has been taken. Random idle gaps between beats and random commands keep every code inside the 4-bit field, and the rejects are directed cases at the edges of the legal range.

// File: rtl/pq_pkg.sv
// Shared types and constants for the P/Q syndrome engine.
// Assumes byte-wide Galois arithmetic over GF(2^8).
package pq_pkg;
    localparam int BYTE_W = 8;

    // Operation selector carried by every command
    typedef enum logic {
        OP_GEN = 1'b0,
        OP_VAL = 1'b1
    } pq_op_e;

    // Low byte of the reducing polynomial x^8+x^4+x^3+x^2+1
    localparam logic [BYTE_W-1:0] GF_POLY_LOW = 8'h1D;
endpackage

// File: rtl/pq_gf_mul.sv
// Combinational GF(2^8) multiplier, shift-and-reduce form.
// Assumes POLY holds the reducing polynomial without its x^8 term.
module pq_gf_mul #(
    parameter logic [7:0] POLY = pq_pkg::GF_POLY_LOW
) (
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y
);
    // Accumulate a*x^k for every set bit k of b, reducing as the shift overflows
    always_comb begin
        logic [7:0] acc;
        logic [7:0] sh;
        acc = '0;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? POLY : 8'h00);
        end
        y = acc;
    end
endmodule

// File: rtl/pq_lane_combine.sv
// Masks the inactive source lanes and folds the active ones into P and Q.
// Assumes n_active lies in 2..LANES; lanes at or above it contribute zero.
module pq_lane_combine #(
    parameter int LANES = 8,
    parameter int CNT_W = $clog2(LANES + 1)
) (
    input  logic [LANES*8-1:0] src_bus,
    input  logic [LANES*8-1:0] coef_bus,
    input  logic [CNT_W-1:0]   n_active,
    output logic [7:0]         p_out,
    output logic [7:0]         q_out
);
    logic [7:0] lane_byte [LANES];
    logic [7:0] lane_prod [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Zero the lane when it lies beyond the source count
        assign lane_byte[i] = (CNT_W'(i) < n_active) ? src_bus[i*8 +: 8] : 8'h00;

        pq_gf_mul u_mul (
            .a (lane_byte[i]),
            .b (coef_bus[i*8 +: 8]),
            .y (lane_prod[i])
        );
    end

    // XOR-reduce plain bytes into P and weighted bytes into Q
    always_comb begin
        p_out = '0;
        q_out = '0;
        for (int i = 0; i < LANES; i++) begin
            p_out = p_out ^ lane_byte[i];
            q_out = q_out ^ lane_prod[i];
        end
    end
endmodule

// File: rtl/pq_cmd_ctrl.sv
// Command acceptance, legality check and beat counter.
// Assumes the command fields are stable while cmd_valid is high in idle.
module pq_cmd_ctrl #(
    parameter int LANES  = 8,
    parameter int CODE_W = 4,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              in_valid,
    output logic              cmd_ready,
    output logic              in_ready,
    output logic              cmd_take,
    output logic              beat,
    output logic              done,
    output logic              err
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(LANES - 2);

    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e              state;
    logic [LEN_W-1:0] remain;
    logic             cmd_ok;

    assign cmd_ready = (state == ST_IDLE);
    assign in_ready  = (state == ST_RUN);
    assign cmd_take  = cmd_valid && cmd_ready;
    assign beat      = in_valid && in_ready;
    assign cmd_ok    = (cmd_code <= MAX_CODE) && (cmd_len != '0);

    // Sequence idle -> run -> idle, counting beats and pulsing done/err
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (cmd_take) begin
                if (cmd_ok) begin
                    state  <= ST_RUN;
                    remain <= cmd_len;
                end else begin
                    err  <= 1'b1;
                    done <= 1'b1;
                end
            end else if (beat) begin
                remain <= remain - 1'b1;
                if (remain == LEN_W'(1)) begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
            end
        end
    end

    // R10: a running command always has beats left to take
    a_r10_remain_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (remain != '0));

    // R2: a rejected command reports err with done and never opens the data port
    a_r2_reject_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_take && !cmd_ok) |=> (err && done && !in_ready));

    // R10: done is a single-cycle pulse
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/raid_pq_engine.sv
// RAID6 P/Q syndrome engine: generate or validate P and Q over 2..LANES
// byte streams, one byte per source per beat, one-cycle output latency.
// Assumes data beats are offered only after a command has been taken.
module raid_pq_engine #(
    parameter int LANES  = 8,
    parameter int CODE_W = 4,
    parameter int LEN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_op,
    input  logic [CODE_W-1:0]  cmd_code,
    input  logic [LANES*8-1:0] cmd_coef,
    input  logic               cmd_p_off,
    input  logic               cmd_q_off,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LANES*8-1:0] in_src,
    input  logic [7:0]         in_p_ref,
    input  logic [7:0]         in_q_ref,
    output logic               p_valid,
    output logic [7:0]         p_data,
    output logic               q_valid,
    output logic [7:0]         q_data,
    output logic               done,
    output logic               err,
    output logic               p_fail,
    output logic               q_fail
);
    import pq_pkg::*;

    localparam int CNT_W = $clog2(LANES + 1);

    logic               cmd_take;
    logic               beat;
    pq_op_e             cfg_op;
    logic               cfg_p_off;
    logic               cfg_q_off;
    logic [CNT_W-1:0]   cfg_nact;
    logic [LANES*8-1:0] cfg_coef;
    logic [7:0]         p_comb;
    logic [7:0]         q_comb;

    pq_cmd_ctrl #(
        .LANES  (LANES),
        .CODE_W (CODE_W),
        .LEN_W  (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .cmd_len   (cmd_len),
        .in_valid  (in_valid),
        .cmd_ready (cmd_ready),
        .in_ready  (in_ready),
        .cmd_take  (cmd_take),
        .beat      (beat),
        .done      (done),
        .err       (err)
    );

    pq_lane_combine #(
        .LANES (LANES),
        .CNT_W (CNT_W)
    ) u_comb (
        .src_bus  (in_src),
        .coef_bus (cfg_coef),
        .n_active (cfg_nact),
        .p_out    (p_comb),
        .q_out    (q_comb)
    );

    // Capture the command configuration when a command is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_op    <= OP_GEN;
            cfg_p_off <= 1'b0;
            cfg_q_off <= 1'b0;
            cfg_nact  <= CNT_W'(2);
            cfg_coef  <= '0;
        end else if (cmd_take) begin
            cfg_op    <= pq_op_e'(cmd_op);
            cfg_p_off <= cmd_p_off;
            cfg_q_off <= cmd_q_off;
            cfg_nact  <= CNT_W'(cmd_code) + CNT_W'(2);
            cfg_coef  <= cmd_coef;
        end
    end

    // Register the per-beat syndromes with their valids
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_valid <= 1'b0;
            q_valid <= 1'b0;
            p_data  <= '0;
            q_data  <= '0;
        end else begin
            p_valid <= beat && !cfg_p_off;
            q_valid <= beat && !cfg_q_off;
            if (beat) begin
                p_data <= p_comb;
                q_data <= q_comb;
            end
        end
    end

    // Sticky mismatch flags: set by validate beats, cleared by a new command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_fail <= 1'b0;
            q_fail <= 1'b0;
        end else if (cmd_take) begin
            p_fail <= 1'b0;
            q_fail <= 1'b0;
        end else if (beat && cfg_op == OP_VAL) begin
            if (!cfg_p_off && p_comb != in_p_ref) p_fail <= 1'b1;
            if (!cfg_q_off && q_comb != in_q_ref) q_fail <= 1'b1;
        end
    end

    // R8: an output valid only follows an accepted beat
    a_r8_valid_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (p_valid || q_valid) |-> $past(in_valid && in_ready));

    // R9: failure flags hold until a new command is taken
    a_r9_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((p_fail || q_fail) && !(cmd_valid && cmd_ready))
        |=> (p_fail || !$past(p_fail)) && (q_fail || !$past(q_fail)));

    // R9/R7: a P flag appears only in validate mode with P enabled
    a_r7_pfail_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(p_fail) |-> (cfg_op == OP_VAL && !cfg_p_off));

    // R9/R7: a Q flag appears only in validate mode with Q enabled
    a_r7_qfail_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q_fail) |-> (cfg_op == OP_VAL && !cfg_q_off));

    // R10: the command and data ports are never open together
    a_r10_ports_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_ready, in_ready}));
endmodule

// File: tb/test_raid_pq_engine.sv
`timescale 1ns/1ps
module test_raid_pq_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_op = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [63:0] cmd_coef = '0;
    logic        cmd_p_off = 1'b0;
    logic        cmd_q_off = 1'b0;
    logic [15:0] cmd_len = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_src = '0;
    logic [7:0]  in_p_ref = '0;
    logic [7:0]  in_q_ref = '0;
    logic        p_valid, q_valid, done, err, p_fail, q_fail;
    logic [7:0]  p_data, q_data;

    int n_chk = 0;
    int n_err = 0;

    logic [63:0] src_mem [32];
    logic [7:0]  obs_p [32];
    logic [7:0]  obs_q [32];

    always #4 clk = ~clk;

    raid_pq_engine i_raid_pq_engine (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_code(cmd_code), .cmd_coef(cmd_coef), .cmd_p_off(cmd_p_off),
        .cmd_q_off(cmd_q_off), .cmd_len(cmd_len),
        .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
        .in_p_ref(in_p_ref), .in_q_ref(in_q_ref),
        .p_valid(p_valid), .p_data(p_data), .q_valid(q_valid), .q_data(q_data),
        .done(done), .err(err), .p_fail(p_fail), .q_fail(q_fail)
    );

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] prod = '0;
        for (int k = 0; k < 8; k++) if (b[k]) prod = prod ^ (16'(a) << k);
        for (int k = 15; k >= 8; k--) if (prod[k]) prod = prod ^ (16'h011D << (k - 8));
        return prod[7:0];
    endfunction

    function automatic logic [7:0] m_p(input logic [63:0] s, input int n);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r = r ^ s[i*8 +: 8];
        return r;
    endfunction

    function automatic logic [7:0] m_q(input logic [63:0] s, input logic [63:0] c, input int n);
        logic [7:0] r = '0;
        for (int i = 0; i < n; i++) r = r ^ m_mul(s[i*8 +: 8], c[i*8 +: 8]);
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic run_op(input bit op, input logic [3:0] code, input logic [63:0] coef,
                          input bit poff, input bit qoff, input int len,
                          input int bad_p, input int bad_q, input bit gaps);
        int n = int'(code) + 2;
        bit exp_pf = 1'b0;
        bit exp_qf = 1'b0;
        logic [7:0] ep, eq;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_code = code; cmd_coef = coef;
        cmd_p_off = poff; cmd_q_off = qoff; cmd_len = 16'(len);
        chk(cmd_ready == 1'b1, "R10 cmd_ready in idle", cmd_ready, 1);
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(in_ready && !cmd_ready, "R10 running opens data port", {in_ready, cmd_ready}, 2'b10);
        chk(!p_fail && !q_fail, "R9 flags cleared on new command", {p_fail, q_fail}, 0);
        for (int b = 0; b < len; b++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid = 1'b0;
                @(posedge clk); @(negedge clk);
                chk(!p_valid && !q_valid, "R8 no valid without beat", {p_valid, q_valid}, 0);
            end
            ep = m_p(src_mem[b], n);
            eq = m_q(src_mem[b], coef, n);
            in_valid = 1'b1;
            in_src   = src_mem[b];
            if (op) begin
                in_p_ref = (b == bad_p) ? (ep ^ 8'h5A) : ep;
                in_q_ref = (b == bad_q) ? (eq ^ 8'hA5) : eq;
                if (b == bad_p && !poff) exp_pf = 1'b1;
                if (b == bad_q && !qoff) exp_qf = 1'b1;
            end else begin
                in_p_ref = 8'($urandom);
                in_q_ref = 8'($urandom);
            end
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            obs_p[b] = p_data;
            obs_q[b] = q_data;
            chk(p_valid == !poff, "R7/R8 p_valid", p_valid, !poff);
            chk(q_valid == !qoff, "R7/R8 q_valid", q_valid, !qoff);
            if (!poff) chk(p_data == ep, "R3 P byte", p_data, ep);
            if (!qoff) chk(q_data == eq, "R4 Q byte", q_data, eq);
            if (b == len - 1) begin
                chk(done && !err, "R10 done after last beat", {done, err}, 2'b10);
                chk(!in_ready, "R10 exactly len beats", in_ready, 0);
                chk(p_fail == exp_pf, "R9 p_fail final", p_fail, exp_pf);
                chk(q_fail == exp_qf, "R9 q_fail final", q_fail, exp_qf);
            end else begin
                chk(!done && in_ready, "R10 still running", {done, in_ready}, 2'b01);
            end
        end
    endtask

    task automatic reject(input logic [3:0] code, input int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; cmd_len = 16'(len); cmd_op = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        chk(done && err, "R2 reject pulses done and err", {done, err}, 2'b11);
        chk(!in_ready, "R2 no data after reject", in_ready, 0);
        chk(!p_fail && !q_fail, "R2 flags cleared by reject", {p_fail, q_fail}, 0);
        @(posedge clk); @(negedge clk);
        chk(!done && !err && cmd_ready, "R2 single pulse, back to idle", {done, err, cmd_ready}, 3'b001);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
    end

    initial begin
        logic [7:0] g [3];
        logic [7:0] h [2];
        logic [7:0] pa [4];
        logic [7:0] qa [4];
        logic [63:0] a_src [4];
        logic [63:0] coef;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk(cmd_ready && !in_ready && !p_valid && !q_valid && !done && !err && !p_fail && !q_fail,
            "R11 reset state", {cmd_ready, in_ready, p_valid, q_valid, done, err, p_fail, q_fail}, 8'h80);

        // R1/R3/R4: all eight lanes, then two lanes with noisy unused lanes
        for (int b = 0; b < 4; b++) src_mem[b] = {$urandom, $urandom};
        run_op(1'b0, 4'd6, 64'h8040_2010_0804_0201, 1'b0, 1'b0, 4, -1, -1, 1'b0);
        run_op(1'b0, 4'd0, {$urandom, $urandom}, 1'b0, 1'b0, 4, -1, -1, 1'b1);

        // R9: validate, mismatch on first beat only stays set
        for (int b = 0; b < 6; b++) src_mem[b] = {$urandom, $urandom};
        run_op(1'b1, 4'd3, {$urandom, $urandom}, 1'b0, 1'b0, 6, 0, -1, 1'b0);
        run_op(1'b1, 4'd2, {$urandom, $urandom}, 1'b0, 1'b0, 6, -1, 5, 1'b0);

        // R2: rejected codes and zero length, also clearing the flags above
        reject(4'd7, 3);
        reject(4'd15, 3);
        reject(4'd1, 0);

        // R7: disabled syndrome neither shown nor checked
        run_op(1'b1, 4'd4, {$urandom, $urandom}, 1'b1, 1'b0, 5, 1, -1, 1'b1);
        run_op(1'b1, 4'd4, {$urandom, $urandom}, 1'b0, 1'b1, 5, -1, 2, 1'b1);

        // R6: single-source multiply with P off
        for (int b = 0; b < 4; b++) begin
            logic [7:0] x = 8'($urandom);
            src_mem[b] = {{6{8'($urandom)}}, x, x};
        end
        run_op(1'b0, 4'd0, {48'h0, 8'h00, 8'h8E}, 1'b1, 1'b0, 4, -1, -1, 1'b0);
        for (int b = 0; b < 4; b++)
            chk(obs_q[b] == m_mul(8'h8E, src_mem[b][7:0]), "R6 Q equals c times source",
                obs_q[b], m_mul(8'h8E, src_mem[b][7:0]));

        // R5: continuation from a three-source syndrome with two more sources
        for (int i = 0; i < 3; i++) g[i] = 8'($urandom) | 8'h01;
        for (int i = 0; i < 2; i++) h[i] = 8'($urandom) | 8'h02;
        for (int b = 0; b < 4; b++) begin
            a_src[b] = {$urandom, $urandom};
            src_mem[b] = a_src[b];
            pa[b] = m_p(a_src[b], 3);
            qa[b] = m_q(a_src[b], {40'h0, g[2], g[1], g[0]}, 3);
        end
        run_op(1'b0, 4'd1, {40'h0, g[2], g[1], g[0]}, 1'b0, 1'b0, 4, -1, -1, 1'b0);
        for (int b = 0; b < 4; b++)
            src_mem[b] = {24'($urandom), qa[b], qa[b], pa[b], 16'($urandom)};
        run_op(1'b0, 4'd3, {24'h0, 8'h00, 8'h01, 8'h00, h[1], h[0]}, 1'b0, 1'b0, 4, -1, -1, 1'b1);
        for (int b = 0; b < 4; b++) begin
            logic [7:0] fp, fq;
            fp = pa[b] ^ src_mem[b][7:0] ^ src_mem[b][15:8];
            fq = m_q(a_src[b], {40'h0, g[2], g[1], g[0]}, 3)
               ^ m_mul(src_mem[b][7:0], h[0]) ^ m_mul(src_mem[b][15:8], h[1]);
            chk(obs_p[b] == fp, "R5 continued P", obs_p[b], fp);
            chk(obs_q[b] == fq, "R5 continued Q", obs_q[b], fq);
        end

        // Random mix of commands
        for (int t = 0; t < 40; t++) begin
            int len = 1 + int'($urandom % 16);
            for (int b = 0; b < len; b++) src_mem[b] = {$urandom, $urandom};
            coef = {$urandom, $urandom};
            for (int i = 0; i < 8; i++) begin
                int r = int'($urandom % 8);
                if (r == 0) coef[i*8 +: 8] = 8'h00;
                if (r == 1) coef[i*8 +: 8] = 8'h01;
            end
            run_op(1'($urandom), 4'($urandom % 7), coef,
                   ($urandom % 4) == 0, ($urandom % 4) == 0, len,
                   (($urandom % 2) == 0) ? int'($urandom % len) : -1,
                   (($urandom % 2) == 0) ? int'($urandom % len) : -1,
                   1'b1);
        end
        repeat (2) @(negedge clk);
        summary();
    end
endmodule